// File: doc/BRIEF.md
# Up/Down Wiper Position Controller

This block is the digital control section of a stepped potentiometer. A host selects the block by pulling an active-low select line, sets a direction line, and strobes an increment line. Each falling edge of the strobe moves a tap counter one position up or down. The counter covers 100 positions and stops at either end; it never wraps. The counter is decoded into a one-hot select with one line per tap. These lines would drive the analog switches.

When the host deselects the block, the level of the strobe at that moment decides what happens. If the strobe is high, the current position is saved to a retained register that stands in for nonvolatile memory. A busy timer then models the long write time. If the strobe is low, nothing is saved and the block returns straight to standby.

A power-on pulse reloads the counter from the retained register. A cold reset, used only on the very first initialization, clears both the counter and the retained register to position 0. All three control inputs are asynchronous. Each passes through a two-flop synchronizer, and edges are detected on the synchronized copies.

Top module: `wiper_ctl_top`

## Requirements
- R1: The position changes only on a falling edge of `inc` that is seen while `cs_n` is low. Strobes while `cs_n` is high have no effect. A change on the pins shows at `tap_pos` after the third rising clock edge.
- R2: With `up_dn`=1 a counted edge adds one to the position; with `up_dn`=0 it subtracts one. The direction may change during a single selection.
- R3: `tap_pos` stays within 0..99. Upward edges at 99 and downward edges at 0 leave the position unchanged.
- R4: A rising `cs_n` seen while `inc` is high copies the position into the retained register. `store_busy` is then high for exactly STORE_CYCLES clock cycles.
- R5: A rising `cs_n` seen while `inc` is low leaves the retained register unchanged. It raises no busy, and `standby` goes high at once.
- R6: `cold_rst` sets the position to 0, clears the retained register to 0, sets `tap_sel` to bit 0, sets `standby`=1 and sets `store_busy`=0. `por` loads the position from the retained register and keeps that register.
- R7: `standby` is high exactly when the synchronized `cs_n` is high and no store is busy.
- R8: `tap_sel` has exactly one bit set. Bit i is set when `tap_pos` was i one clock earlier.
- R9: Increment edges and deselects that arrive while `store_busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| cold_rst | input | 1 | Synchronous first-ever initialization; clears the position and the retained copy |
| por | input | 1 | Synchronous power-up recall of the retained position |
| cs_n | input | 1 | Active-low select, asynchronous |
| inc | input | 1 | Increment strobe, falling-edge active, asynchronous |
| up_dn | input | 1 | Direction: 1 up, 0 down, asynchronous |
| tap_pos | output | 7 | Current tap counter |
| tap_sel | output | 100 | One-hot tap select, registered |
| store_busy | output | 1 | High while a save is in progress |
| standby | output | 1 | High when deselected and idle |

## Verification
Properties are checked on every cycle:
- the position stays in range and moves by at most one step per cycle;
- the select vector is one-hot and follows the previous position;
- the position is frozen while a save is busy;
- the busy window has the exact configured length;
- standby is never high during a save.

Only the bench scenarios can show the behaviour that depends on history. That covers which deselect level actually saves, what a later power-up recalls, saturation after long runs of strobes, and changing direction within one selection.

// File: rtl/wc_pkg.sv
package wc_pkg;
  typedef struct packed {
    logic cs_n;
    logic inc;
    logic up;
  } wc_ctl_t;

  localparam wc_ctl_t WC_IDLE = '{cs_n: 1'b1, inc: 1'b1, up: 1'b0};

  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} wc_store_st_t;
endpackage

// File: rtl/wc_sync.sv
module wc_sync #(
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             clr,
  input  wc_pkg::wc_ctl_t  raw,
  output wc_pkg::wc_ctl_t  lvl,
  output logic             inc_fall,
  output logic             cs_rise
);
  import wc_pkg::*;
  localparam int NB = $bits(wc_ctl_t);

  logic [NB-1:0] raw_v;
  logic [NB-1:0] lvl_v;
  logic [NB-1:0] idle_v;
  wc_ctl_t       prev_q;

  assign raw_v  = raw;
  assign idle_v = WC_IDLE;

  for (genvar b = 0; b < NB; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (clr) chain_q <= {STAGES{idle_v[b]}};
      else     chain_q <= {chain_q[STAGES-2:0], raw_v[b]};
    end
    assign lvl_v[b] = chain_q[STAGES-1];
  end

  assign lvl = wc_ctl_t'(lvl_v);

  always_ff @(posedge clk) begin
    if (clr) prev_q <= WC_IDLE;
    else     prev_q <= lvl;
  end

  assign inc_fall = prev_q.inc & ~lvl.inc;
  assign cs_rise  = ~prev_q.cs_n & lvl.cs_n;
endmodule

// File: rtl/wc_counter.sv
module wc_counter #(
  parameter int NUM_TAPS = 100,
  parameter int CNT_W    = 7
) (
  input  logic             clk,
  input  logic             cold_rst,
  input  logic             por,
  input  logic             step_en,
  input  logic             up,
  input  logic [CNT_W-1:0] recall_val,
  output logic [CNT_W-1:0] pos
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(NUM_TAPS - 1);

  logic [CNT_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (cold_rst) begin
      pos_q <= '0;
    end else if (por) begin
      pos_q <= recall_val;
    end else if (step_en) begin
      if (up && pos_q != TOP)         pos_q <= pos_q + 1'b1;
      else if (!up && pos_q != '0)    pos_q <= pos_q - 1'b1;
    end
  end

  assign pos = pos_q;
endmodule

// File: rtl/wc_store.sv
module wc_store #(
  parameter int CNT_W        = 7,
  parameter int STORE_CYCLES = 20
) (
  input  logic             clk,
  input  logic             cold_rst,
  input  logic             por,
  input  logic             cs_rise,
  input  logic             inc_lvl,
  input  logic             cs_lvl,
  input  logic [CNT_W-1:0] pos,
  output logic [CNT_W-1:0] kept,
  output logic             busy,
  output logic             standby
);
  import wc_pkg::*;
  localparam int TMR_W = (STORE_CYCLES > 1) ? $clog2(STORE_CYCLES) : 1;
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(STORE_CYCLES - 1);

  wc_store_st_t     st_q, st_nx;
  logic [TMR_W-1:0] tmr_q, tmr_nx;
  logic [CNT_W-1:0] kept_q;
  logic             stby_q;
  logic             do_save;

  assign do_save = cs_rise & inc_lvl & (st_q == ST_IDLE);

  always_comb begin
    st_nx  = st_q;
    tmr_nx = tmr_q;
    if (st_q == ST_BUSY) begin
      if (tmr_q == '0) st_nx = ST_IDLE;
      else             tmr_nx = tmr_q - 1'b1;
    end
    if (do_save) begin
      st_nx  = ST_BUSY;
      tmr_nx = TMR_LOAD;
    end
  end

  always_ff @(posedge clk) begin
    if (cold_rst) kept_q <= '0;
    else if (!por && do_save) kept_q <= pos;
  end

  always_ff @(posedge clk) begin
    if (cold_rst || por) begin
      st_q   <= ST_IDLE;
      tmr_q  <= '0;
      stby_q <= 1'b1;
    end else begin
      st_q   <= st_nx;
      tmr_q  <= tmr_nx;
      stby_q <= cs_lvl & (st_nx == ST_IDLE);
    end
  end

  assign kept    = kept_q;
  assign busy    = (st_q == ST_BUSY);
  assign standby = stby_q;
endmodule

// File: rtl/wc_decode.sv
module wc_decode #(
  parameter int NUM_TAPS = 100,
  parameter int CNT_W    = 7
) (
  input  logic                clk,
  input  logic                cold_rst,
  input  logic [CNT_W-1:0]    pos,
  output logic [NUM_TAPS-1:0] sel
);
  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    logic hit_q;
    always_ff @(posedge clk) begin
      if (cold_rst) hit_q <= (i == 0);
      else          hit_q <= (pos == CNT_W'(i));
    end
    assign sel[i] = hit_q;
  end
endmodule

// File: rtl/wiper_ctl_top.sv
module wiper_ctl_top #(
  parameter int NUM_TAPS     = 100,
  parameter int STORE_CYCLES = 20,
  parameter int SYNC_STAGES  = 2,
  localparam int CNT_W       = $clog2(NUM_TAPS)
) (
  input  logic                clk,
  input  logic                cold_rst,
  input  logic                por,
  input  logic                cs_n,
  input  logic                inc,
  input  logic                up_dn,
  output logic [CNT_W-1:0]    tap_pos,
  output logic [NUM_TAPS-1:0] tap_sel,
  output logic                store_busy,
  output logic                standby
);
  import wc_pkg::*;

  wc_ctl_t          raw, lvl;
  logic             inc_fall, cs_rise, step_en;
  logic [CNT_W-1:0] kept;

  assign raw = '{cs_n: cs_n, inc: inc, up: up_dn};

  wc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .clr(cold_rst | por), .raw(raw), .lvl(lvl),
    .inc_fall(inc_fall), .cs_rise(cs_rise)
  );

  assign step_en = inc_fall & ~lvl.cs_n & ~store_busy;

  wc_counter #(.NUM_TAPS(NUM_TAPS), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .cold_rst(cold_rst), .por(por), .step_en(step_en),
    .up(lvl.up), .recall_val(kept), .pos(tap_pos)
  );

  wc_store #(.CNT_W(CNT_W), .STORE_CYCLES(STORE_CYCLES)) u_store (
    .clk(clk), .cold_rst(cold_rst), .por(por), .cs_rise(cs_rise),
    .inc_lvl(lvl.inc), .cs_lvl(lvl.cs_n), .pos(tap_pos),
    .kept(kept), .busy(store_busy), .standby(standby)
  );

  wc_decode #(.NUM_TAPS(NUM_TAPS), .CNT_W(CNT_W)) u_dec (
    .clk(clk), .cold_rst(cold_rst), .pos(tap_pos), .sel(tap_sel)
  );
endmodule

// File: rtl/wc_checker.sv
module wc_checker #(
  parameter int NUM_TAPS     = 100,
  parameter int STORE_CYCLES = 20,
  localparam int CNT_W       = $clog2(NUM_TAPS)
) (
  input logic                clk,
  input logic                cold_rst,
  input logic                por,
  input logic [CNT_W-1:0]    tap_pos,
  input logic [NUM_TAPS-1:0] tap_sel,
  input logic                store_busy,
  input logic                standby
);
  localparam logic [NUM_TAPS-1:0] ONE = NUM_TAPS'(1);
  int busy_run;

  always_ff @(posedge clk) begin
    if (cold_rst || por) busy_run <= 0;
    else if (store_busy) busy_run <= busy_run + 1;
    else busy_run <= 0;
  end

  a_r3_in_range: assert property (@(posedge clk) disable iff (cold_rst)
    int'(tap_pos) <= NUM_TAPS - 1);

  a_r3_single_step: assert property (@(posedge clk) disable iff (cold_rst || por)
    !$past(por) && !$past(cold_rst) |->
      (tap_pos == $past(tap_pos)) || (tap_pos == $past(tap_pos) + 1'b1) ||
      ($past(tap_pos) == tap_pos + 1'b1));

  a_r8_onehot: assert property (@(posedge clk) disable iff (cold_rst)
    $countones(tap_sel) == 1);

  a_r8_follows: assert property (@(posedge clk) disable iff (cold_rst)
    !$past(cold_rst) |-> tap_sel == (ONE << $past(tap_pos)));

  a_r9_frozen: assert property (@(posedge clk) disable iff (cold_rst || por)
    $past(store_busy) && !$past(por) && !$past(cold_rst) |-> $stable(tap_pos));

  a_r4_busy_len: assert property (@(posedge clk) disable iff (cold_rst || por)
    $fell(store_busy) && !$past(por) |-> busy_run == STORE_CYCLES);

  a_r7_no_standby_busy: assert property (@(posedge clk) disable iff (cold_rst)
    store_busy |-> !standby);
endmodule

bind wiper_ctl_top wc_checker #(.NUM_TAPS(NUM_TAPS), .STORE_CYCLES(STORE_CYCLES)) u_chk (
  .clk(clk), .cold_rst(cold_rst), .por(por), .tap_pos(tap_pos),
  .tap_sel(tap_sel), .store_busy(store_busy), .standby(standby)
);

// File: tb/wiper_ctl_top_tb_top.sv
module wiper_ctl_top_tb_top;
  localparam int CLK_P  = 10;
  localparam int TAPS   = 100;
  localparam int STORE  = 20;

  logic        clk = 1'b0;
  logic        cold_rst = 1'b1, por = 1'b0;
  logic        cs_n = 1'b1, inc = 1'b1, up_dn = 1'b0;
  logic [6:0]  tap_pos;
  logic [TAPS-1:0] tap_sel;
  logic        store_busy, standby;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  wiper_ctl_top #(.NUM_TAPS(TAPS), .STORE_CYCLES(STORE)) dut_i (
    .clk(clk), .cold_rst(cold_rst), .por(por), .cs_n(cs_n), .inc(inc),
    .up_dn(up_dn), .tap_pos(tap_pos), .tap_sel(tap_sel),
    .store_busy(store_busy), .standby(standby)
  );

  // behavioural reference: history queue of pin samples, integer state
  logic [2:0] hist[$];
  int  m_pos, m_kept, m_sel, m_left;
  bit  m_busy, m_stby, m_live;

  always @(posedge clk) begin
    logic [2:0] cur, prv;
    int  n_pos, n_left;
    bit  n_busy;
    if (cold_rst || por) begin
      hist = '{3'b110, 3'b110, 3'b110};
      m_sel = cold_rst ? 0 : m_pos;
      if (cold_rst) begin m_pos = 0; m_kept = 0; end
      else m_pos = m_kept;
      m_busy = 0; m_left = 0; m_stby = 1; m_live = 1;
    end else if (m_live) begin
      cur = hist[1]; prv = hist[2];
      n_pos = m_pos; n_busy = m_busy; n_left = m_left;
      if (m_busy) begin
        if (m_left == 0) n_busy = 0; else n_left = m_left - 1;
      end
      if (prv[1] && !cur[1] && !cur[2] && !m_busy) begin
        if (cur[0]) n_pos = (m_pos < TAPS-1) ? m_pos + 1 : m_pos;
        else        n_pos = (m_pos > 0) ? m_pos - 1 : m_pos;
      end
      if (!prv[2] && cur[2] && cur[1] && !m_busy) begin
        m_kept = m_pos; n_busy = 1; n_left = STORE - 1;
      end
      m_stby = cur[2] && !n_busy;
      m_sel = m_pos; m_pos = n_pos; m_busy = n_busy; m_left = n_left;
      hist.push_front({cs_n, inc, up_dn});
      void'(hist.pop_back());
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (m_live && !cold_rst) begin
      chk("R3 model position", int'(tap_pos), m_pos);
      chk("R8 model select", (tap_sel == (TAPS'(1) << m_sel)) ? 1 : 0, 1);
      chk("R4 model busy", int'(store_busy), int'(m_busy));
      chk("R7 model standby", int'(standby), int'(m_stby));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic strobe(bit dir);
    up_dn = dir; inc = 1'b0; cyc(3); inc = 1'b1; cyc(3);
  endtask
  task automatic pulse_por();
    por = 1'b1; cyc(1); por = 1'b0; cyc(2);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3); cold_rst = 1'b0; cyc(1);
    // R6 cold reset state
    chk("R6 reset pos", int'(tap_pos), 0);
    chk("R6 reset sel bit0", int'(tap_sel[0]), 1);
    chk("R6 reset standby", int'(standby), 1);
    chk("R6 reset busy", int'(store_busy), 0);
    // R1 strobes while deselected are ignored
    strobe(1'b1); strobe(1'b1); cyc(3);
    chk("R1 deselected strobe", int'(tap_pos), 0);
    // R2 up then down in one selection
    cs_n = 1'b0; cyc(3);
    chk("R7 selected standby", int'(standby), 0);
    repeat (5) strobe(1'b1);
    cyc(3);
    chk("R2 up five", int'(tap_pos), 5);
    chk("R8 select bit5", int'(tap_sel[5]), 1);
    repeat (2) strobe(1'b0);
    cyc(3);
    chk("R2 direction change", int'(tap_pos), 3);
    // R5 deselect with inc low: no save
    inc = 1'b0; cs_n = 1'b1; cyc(3); inc = 1'b1; cyc(3);
    chk("R5 no busy", int'(store_busy), 0);
    chk("R5 standby", int'(standby), 1);
    chk("R5 pos kept live", int'(tap_pos), 3);
    pulse_por(); cyc(1);
    chk("R5 R6 recall unchanged copy", int'(tap_pos), 0);
    // R4 save with inc high
    cs_n = 1'b0; cyc(3);
    repeat (4) strobe(1'b1);
    cyc(3);
    cs_n = 1'b1; cyc(4);
    chk("R4 busy after save", int'(store_busy), 1);
    chk("R7 standby low while busy", int'(standby), 0);
    // R9 activity during busy ignored
    cs_n = 1'b0; strobe(1'b1); strobe(1'b1);
    cs_n = 1'b1; cyc(3);
    chk("R9 pos frozen", int'(tap_pos), 4);
    cyc(STORE + 5);
    chk("R4 busy done", int'(store_busy), 0);
    chk("R7 standby after save", int'(standby), 1);
    // move away, deselect without save, recall
    cs_n = 1'b0; cyc(3);
    strobe(1'b1); strobe(1'b1); cyc(3);
    chk("R2 up two", int'(tap_pos), 6);
    inc = 1'b0; cs_n = 1'b1; cyc(3); inc = 1'b1; cyc(3);
    pulse_por(); cyc(1);
    chk("R6 recall saved", int'(tap_pos), 4);
    // R3 saturation at both ends
    cs_n = 1'b0; cyc(3);
    repeat (100) strobe(1'b1);
    cyc(3);
    chk("R3 top", int'(tap_pos), 99);
    chk("R8 select bit99", int'(tap_sel[99]), 1);
    repeat (2) strobe(1'b1);
    cyc(3);
    chk("R3 hold top", int'(tap_pos), 99);
    repeat (102) strobe(1'b0);
    cyc(3);
    chk("R3 bottom", int'(tap_pos), 0);
    chk("R8 select bit0", int'(tap_sel[0]), 1);
    inc = 1'b0; cs_n = 1'b1; cyc(3); inc = 1'b1; cyc(5);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule